// File: doc/BRIEF.md
# Prescaled Phase-Accumulator Pulse Generator

This block drives one output pin from a numerically controlled oscillator. A prescaler counts system clocks to form a base period. At the end of each base period, a programmable increment is added into a phase accumulator. The pin shows either the accumulator's top bit, which gives a square-ish wave, or a one-clock pulse on each wrap of the accumulator, which gives a pulse train. In both cases the average rate is the increment divided by 2^32, times the step rate.

A sticky event flag records every wrap until it is acknowledged. Dropping the enable clears all state and holds the outputs low. Output edges can only fall on system clock edges. A non-integer ratio therefore makes the period alternate between neighbouring whole clock counts.

Top module: `phase_pulse_nco`

## Requirements
- R1: While `en` is low, `pin_out` and `event_flag` are low. The accumulator, the pulse and the prescaler count are cleared at the next clock edge, so after re-enabling the sequence starts again from zero.
- R2: With `base_period` = P in 1..65535, the accumulator steps on the P-th rising edge after `en` goes high and then on every P-th edge after that. With P = 1 it steps on every edge.
- R3: A `base_period` of 0 gives a base period of 65536 clocks.
- R4: Each step replaces the accumulator with (accumulator + `incr`) mod 2^32.
- R5: With `mode` = 0 (frequency), `pin_out` equals bit 31 of the accumulator.
- R6: With `mode` = 1 (duty), `pin_out` is high for exactly the one clock after each step whose addition carried out of bit 31, and is low otherwise.
- R7: Starting from a cleared accumulator, the number of duty-mode pulses after N steps is floor(N·`incr`/2^32). For example, 100 steps with `incr` = 0x4CCCCCCD give 30 pulses.
- R8: `event_flag` goes high in the clock after a step that carries out, and stays high until a clock edge at which `ack` is high and no carry occurs.
- R9: When `ack` is high at the same edge as a carrying step, `event_flag` is set.
- R10: `incr` is sampled only at steps. Changing it between steps does not alter or clear the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears all state |
| mode | input | 1 | 0 = accumulator MSB output, 1 = carry pulse output |
| base_period | input | 16 | Base period in system clocks (0 means 65536) |
| incr | input | 32 | Phase increment added per base period |
| ack | input | 1 | Clears the event flag |
| pin_out | output | 1 | Oscillator output |
| event_flag | output | 1 | Sticky accumulator-wrap flag |

## Verification
The bench targets several corner cases:
- A period value of 0. A prescaler that treats it literally would step on every clock instead of once every 65536 clocks.
- The same-cycle collision of `ack` and a carry. A clear-first flag would drop the event.
- A fractional ratio in duty mode. A mis-sized sum or carry would give the wrong pulse count over 100 steps.
- Changing `incr` in the middle of a period and dropping `en` in the middle of a run. These expose designs that reset the phase on a write, or that fail to restart the prescaler from zero.

// File: rtl/nco_pkg.sv
package nco_pkg;

   typedef enum logic {
      NCO_MSB_OUT   = 1'b0,
      NCO_CARRY_OUT = 1'b1
   } nco_mode_e;

   // Terminal count of the prescaler: a zero period wraps to all ones,
   // which is a period of 2**w clocks.
   function automatic logic [15:0] nco_last16(input logic [15:0] per);
      return per - 16'd1;
   endfunction

endpackage

// File: rtl/nco_base_timer.sv
module nco_base_timer #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PER_W-1:0] period,
   output logic             tick
);

   localparam logic [PER_W-1:0] ONE = {{(PER_W-1){1'b0}}, 1'b1};

   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] last_cnt;

   if (PER_W < 1) begin : g_bad_width
      $error("nco_base_timer: PER_W must be at least 1");
   end

   // Wrap-around subtraction makes a zero period mean 2**PER_W clocks.
   assign last_cnt = period - ONE;
   assign tick     = en && (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   // R2: no two steps on neighbouring edges unless the period is one
   a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      en && tick && period != ONE |=> !tick || period == ONE || !$stable(period));

   // R1: a disabled timer restarts from zero
   a_r1_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt_q == '0);

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [ACC_W-1:0] incr,
   output logic             acc_msb,
   output logic             carry_now,
   output logic             carry_pulse
);

   logic [ACC_W-1:0] acc_q;
   logic             carry_q;
   logic [ACC_W:0]   sum;

   if (ACC_W < 2) begin : g_bad_width
      $error("nco_phase_acc: ACC_W must be at least 2");
   end

   assign sum       = {1'b0, acc_q} + {1'b0, incr};
   assign carry_now = en && tick && sum[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         carry_q <= 1'b0;
      end else if (!en) begin
         acc_q   <= '0;
         carry_q <= 1'b0;
      end else if (tick) begin
         acc_q   <= sum[ACC_W-1:0];
         carry_q <= sum[ACC_W];
      end else begin
         carry_q <= 1'b0;
      end
   end

   assign acc_msb     = acc_q[ACC_W-1];
   assign carry_pulse = carry_q;

   // R4: a step adds the increment modulo 2**ACC_W
   a_r4_step_adds: assert property (@(posedge clk) disable iff (!rst_n)
      en && tick |=> !en || acc_q == $past(acc_q + incr));

   // R10: between steps the phase is held whatever incr does
   a_r10_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
      en && !tick |=> !en || $stable(acc_q));

   // R1: disabling clears the phase and the pulse
   a_r1_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> acc_q == '0 && !carry_q);

   // R6: a pulse only ever follows a step
   a_r6_pulse_after_step: assert property (@(posedge clk) disable iff (!rst_n)
      carry_q |-> $past(tick));

endmodule

// File: rtl/nco_event_latch.sv
module nco_event_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic set,
   input  logic ack,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (!en) begin
         flag_q <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
      end else if (ack) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;

   // R8: the flag holds until acknowledged
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      en && flag_q && !ack |=> !en || flag_q);

   // R9: a set in the acknowledge cycle is not lost
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      en && set && ack |=> !en || flag_q);

endmodule

// File: rtl/phase_pulse_nco.sv
module phase_pulse_nco #(
   parameter int ACC_W        = 32,
   parameter int PER_W        = 16,
   parameter bit CARRY_OUT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             mode,
   input  logic [PER_W-1:0] base_period,
   input  logic [ACC_W-1:0] incr,
   input  logic             ack,
   output logic             pin_out,
   output logic             event_flag
);
   import nco_pkg::*;

   logic tick;
   logic acc_msb;
   logic carry_now;
   logic carry_pulse;
   logic flag_raw;
   logic pin_sel;

   nco_base_timer #(.PER_W(PER_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .period (base_period),
      .tick   (tick)
   );

   nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .tick        (tick),
      .incr        (incr),
      .acc_msb     (acc_msb),
      .carry_now   (carry_now),
      .carry_pulse (carry_pulse)
   );

   nco_event_latch u_event (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .set   (carry_now),
      .ack   (ack),
      .flag  (flag_raw)
   );

   if (CARRY_OUT_EN) begin : g_two_modes
      nco_mode_e mode_e;
      assign mode_e  = nco_mode_e'(mode);
      assign pin_sel = (mode_e == NCO_CARRY_OUT) ? carry_pulse : acc_msb;
   end else begin : g_msb_only
      logic unused_mode;
      assign unused_mode = mode;
      assign pin_sel     = acc_msb;
   end

   assign pin_out    = en && pin_sel;
   assign event_flag = en && flag_raw;

   // R8: every carry pulse is accompanied by the flag
   a_r8_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      en && carry_pulse |-> event_flag);

   // R1: outputs quiet while disabled (checked one edge after disable)
   a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en ##1 !en |-> !pin_out && !event_flag);

endmodule

// File: tb/phase_pulse_nco_bench.sv
module phase_pulse_nco_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        mode = 1'b0;
   logic [15:0] base_period = 16'd1;
   logic [31:0] incr = 32'd0;
   logic        ack = 1'b0;
   logic        pin_out;
   logic        event_flag;

   int n_vec = 0;
   int n_bad = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;
   string cur_req = "R1";

   typedef struct {
      logic  pin;
      logic  flg;
      string req;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_pulse_nco u_phase_pulse_nco (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .mode        (mode),
      .base_period (base_period),
      .incr        (incr),
      .ack         (ack),
      .pin_out     (pin_out),
      .event_flag  (event_flag)
   );

   // Reference model built from the requirements
   int unsigned m_cnt = 0;
   logic [31:0] m_acc = '0;
   logic        m_car = 1'b0;
   logic        m_flag = 1'b0;

   always @(posedge clk) begin
      if (!rst_n || !en) begin
         m_cnt  = 0;
         m_acc  = '0;
         m_car  = 1'b0;
         m_flag = 1'b0;
      end else begin
         int unsigned per;
         logic [32:0] s;
         per = (base_period == 16'd0) ? 65536 : int'(base_period);
         if (m_cnt + 1 == per) begin
            m_cnt = 0;
            s     = {1'b0, m_acc} + {1'b0, incr};
            m_acc = s[31:0];
            m_car = s[32];
         end else begin
            m_cnt = m_cnt + 1;
            m_car = 1'b0;
         end
         if (m_car) m_flag = 1'b1;
         else if (ack) m_flag = 1'b0;
      end
   end

   // Driver side of the scoreboard: expected outputs pushed each cycle
   always @(negedge clk) begin
      if (mon_on && !done) begin
         exp_t e;
         e.pin = en && (mode ? m_car : m_acc[31]);
         e.flg = en && m_flag;
         e.req = cur_req;
         sb_q.push_back(e);
      end
   end

   // Monitor: pop and compare
   always @(negedge clk) begin
      #1;
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_vec++;
         if (pin_out !== e.pin || event_flag !== e.flg) begin
            n_bad++;
            $display("FAIL %s: pin/flag actual %b/%b expected %b/%b at %0t",
                     e.req, pin_out, event_flag, e.pin, e.flg, $time);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string req);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_int(input int act, input int exp, input string req);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      int cnt;
      // R1: reset state
      step(3);
      chk(pin_out, 1'b0, "R1 reset pin");
      chk(event_flag, 1'b0, "R1 reset flag");
      rst_n = 1'b1;
      step(1);
      mon_on = 1'b1;

      // R5/R2: frequency mode, step every clock
      cur_req = "R5"; mode = 1'b0; base_period = 16'd1; incr = 32'h4000_0000;
      en = 1'b1;
      step(12);
      // R2: period 3, duty mode
      cur_req = "R2"; en = 1'b0; step(1);
      mode = 1'b1; base_period = 16'd3; incr = 32'h8000_0000; en = 1'b1;
      step(2);
      chk(pin_out, 1'b0, "R2 no step before third edge");
      step(1);
      chk(pin_out, 1'b0, "R2 first step has no carry");
      step(24);

      // R6: duty pulses one clock wide
      cur_req = "R6"; en = 1'b0; step(1);
      base_period = 16'd2; incr = 32'hC000_0000; en = 1'b1;
      step(40);

      // R7: fractional ratio pulse count
      cur_req = "R7"; en = 1'b0; step(1);
      mode = 1'b1; base_period = 16'd1; incr = 32'h4CCC_CCCD; en = 1'b1;
      cnt = 0;
      for (int i = 0; i < 100; i++) begin
         step(1);
         if (pin_out) cnt++;
      end
      chk_int(cnt, 30, "R7 pulses over 100 steps");

      // R8: sticky flag and acknowledge
      cur_req = "R8"; en = 1'b0; step(1);
      base_period = 16'd4; incr = 32'hA000_0000; en = 1'b1;
      step(8);
      chk(event_flag, 1'b1, "R8 flag after wrap");
      step(1);
      chk(event_flag, 1'b1, "R8 flag sticky");
      ack = 1'b1; step(1); ack = 1'b0;
      chk(event_flag, 1'b0, "R8 ack clears");
      step(20);

      // R9: ack held, carries on every second step
      cur_req = "R9"; en = 1'b0; step(1);
      base_period = 16'd1; incr = 32'h8000_0000; ack = 1'b1; en = 1'b1;
      cnt = 0;
      for (int i = 0; i < 10; i++) begin
         step(1);
         if (event_flag) cnt++;
      end
      chk_int(cnt, 5, "R9 flag set despite ack");
      ack = 1'b0;

      // R10: incr changed mid-period keeps phase
      cur_req = "R10"; en = 1'b0; step(1);
      mode = 1'b0; base_period = 16'd5; incr = 32'h6000_0000; en = 1'b1;
      step(7);
      incr = 32'h2000_0000;
      step(2);
      chk(pin_out, 1'b0, "R10 phase kept before boundary");
      step(1);
      chk(pin_out, 1'b1, "R10 new incr at boundary");
      step(15);

      // R1: disable mid-run and restart
      cur_req = "R1"; en = 1'b0; step(2);
      chk(pin_out, 1'b0, "R1 pin off");
      chk(event_flag, 1'b0, "R1 flag off");
      en = 1'b1; step(10);

      // R3: zero period is 65536 clocks
      cur_req = "R3"; en = 1'b0; step(1);
      mode = 1'b0; base_period = 16'd0; incr = 32'h8000_0000; en = 1'b1;
      step(65535);
      chk(pin_out, 1'b0, "R3 no step before 65536");
      step(1);
      chk(pin_out, 1'b1, "R3 step at 65536");
      chk(event_flag, 1'b0, "R4 no wrap yet");
      step(3);

      mon_on = 1'b0;
      step(2);
      finish_run();
   end

endmodule